// File: doc/BRIEF.md
# Multicart Outer Bank Combiner

This block sits between the inner bank-select logic of a multi-game cartridge and the ROM address decode. It holds four outer configuration registers that choose which game's slice of PRG and CHR ROM is visible. It merges those registers with the inner bank numbers to produce the final ROM bank numbers.

Software loads the outer registers through a single write strobe. A two-bit index points at the next register, advances after every accepted write, and wraps from the last register back to the first. Writing a register image with the lock bit set freezes the whole configuration until reset. The PRG path clears selected low bits of each 8 KB inner bank and ORs in an outer base. The CHR path masks each 1 KB inner bank with a mask decoded from a size code. It then ORs in an outer base and adds a high select bit as bank-number bit 8.

Top module: `mc_outer_bank`

## Requirements
- R1: After a synchronous active-low reset, all four outer registers and the write index are zero. Each final PRG bank then equals its inner bank with bits 7:6 cleared, and each final CHR bank is zero.
- R2: Accepted writes land in register 0, then 1, 2 and 3 in turn, and the index then wraps to register 0.
- R3: While `cfg_we` is low, the outer registers and the index keep their values, whatever `cfg_wdata` carries.
- R4: Bit 6 of register 3 is a lock. While it is set, writes are dropped and the index stays put, so the final bank outputs do not change in response to writes. A write that sets the lock is itself accepted.
- R5: Each final PRG bank is formed in three steps. The six low bits of the inner bank are ANDed with the complement of register 3 bits 5:0. Bits 7:6 are cleared. The result is ORed with all eight bits of register 1.
- R6: The CHR mask comes from register 2 bits 3:0. Codes 0 to 7 give mask 0x00. A code 8+k, with k from 0 to 7, gives a mask with the low k+1 bits set (0x01 up to 0xFF).
- R7: Each final 9-bit CHR bank is {register 2 bit 4, (inner bank AND mask) OR register 0}.
- R8: A register write takes effect on the outputs in the cycle after the strobe's clock edge. A change of an inner bank shows on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Single-cycle write strobe for the configuration window |
| cfg_wdata | input | 8 | Data for the register under the index |
| inner_prg | input | 32 | Four 8-bit inner PRG bank numbers, slot 0 in bits 7:0 |
| inner_chr | input | 64 | Eight 8-bit inner CHR bank numbers, slot 0 in bits 7:0 |
| final_prg | output | 32 | Four 8-bit final PRG bank numbers, slot 0 in bits 7:0 |
| final_chr | output | 72 | Eight 9-bit final CHR bank numbers, slot 0 in bits 8:0 |

## Verification
A configuration write and a change of the inner bank numbers can fall in the same cycle. The bench provokes this by presenting new inner banks together with a raised strobe. While the strobe is still high it checks that the outputs combine the new inner banks with the old registers. After the edge it checks that they combine the same inner banks with the newly written register. The write that sets the lock meets the same rule: it lands, and every write after it is judged against the unchanged outputs.

// File: rtl/obm_pkg.sv
// Package: shared sizes for the outer bank combiner.
// Assumes four outer registers and the fixed roles described in the brief.
package obm_pkg;
    localparam int NUM_CFG  = 4;                 // outer register count
    localparam int IDX_W    = $clog2(NUM_CFG);   // write index width
    localparam int CHR_BASE = 0;                 // register OR-ed into CHR banks
    localparam int PRG_BASE = 1;                 // register OR-ed into PRG banks
    localparam int CHR_SIZE = 2;                 // mask code and high CHR select
    localparam int PRG_CTRL = 3;                 // PRG clear bits and lock
    localparam int LOCK_BIT = 6;                 // lock bit inside PRG_CTRL
    localparam int HI_BIT   = 4;                 // high CHR select inside CHR_SIZE
endpackage

// File: rtl/obm_cfg_regs.sv
// Module: outer register file with an auto-advancing write index.
// Assumes cfg_we is a one-cycle pulse; once the lock bit is set only reset clears it.
module obm_cfg_regs #(
    parameter int REG_W = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_en,
    input  logic [REG_W-1:0]                          wr_data,
    output logic [obm_pkg::NUM_CFG-1:0][REG_W-1:0]    cfg_q,
    output logic [obm_pkg::IDX_W-1:0]                 idx_q,
    output logic                                      locked
);
    import obm_pkg::*;

    // Lock flag read straight from the control register.
    assign locked = cfg_q[PRG_CTRL][LOCK_BIT];

    // Store the write at the index and step the index, unless locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            idx_q <= '0;
        end else if (wr_en && !locked) begin
            cfg_q[idx_q] <= wr_data;
            idx_q        <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/obm_prg_map.sv
// Module: final PRG bank builder, one combinational lane per 8 KB slot.
// Assumes REG_W >= CUT_W; bits above CUT_W of the inner bank are discarded.
module obm_prg_map #(
    parameter int REG_W = 8,
    parameter int SLOTS = 4,
    parameter int CUT_W = 6
) (
    input  logic [REG_W-1:0]       clr_bits,
    input  logic [REG_W-1:0]       base,
    input  logic [SLOTS*REG_W-1:0] inner,
    output logic [SLOTS*REG_W-1:0] final_bank
);
    localparam int PAD_W = REG_W - CUT_W;

    logic [CUT_W-1:0] keep;

    // Bits that survive the clear mask.
    assign keep = ~clr_bits[CUT_W-1:0];

    for (genvar s = 0; s < SLOTS; s++) begin : g_lane
        logic [CUT_W-1:0] low;
        // Clear, truncate and merge with the outer base.
        always_comb begin
            low = inner[s*REG_W +: CUT_W] & keep;
            final_bank[s*REG_W +: REG_W] = {{PAD_W{1'b0}}, low} | base;
        end
    end
endmodule

// File: rtl/obm_chr_map.sv
// Module: CHR mask decoder plus final CHR bank builder per 1 KB slot.
// Assumes a 4-bit size code: top bit off gives an empty mask.
module obm_chr_map #(
    parameter int REG_W = 8,
    parameter int SLOTS = 8
) (
    input  logic [3:0]               size_code,
    input  logic                     hi_sel,
    input  logic [REG_W-1:0]         base,
    input  logic [SLOTS*REG_W-1:0]   inner,
    output logic [REG_W-1:0]         mask,
    output logic [SLOTS*(REG_W+1)-1:0] final_bank
);
    localparam int OUT_W = REG_W + 1;

    logic [REG_W:0] ones;

    // Decode the size code into a run of low ones.
    always_comb begin
        ones = ({{REG_W{1'b0}}, 1'b1} << ({1'b0, size_code[2:0]} + 4'd1)) - 1'b1;
        mask = size_code[3] ? ones[REG_W-1:0] : '0;
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_lane
        // Mask the inner bank, merge the base, prepend the high select.
        always_comb begin
            final_bank[s*OUT_W +: OUT_W] = {hi_sel, (inner[s*REG_W +: REG_W] & mask) | base};
        end
    end
endmodule

// File: rtl/mc_outer_bank.sv
// Module: top of the multicart outer bank combiner.
// Assumes registered outer state and purely combinational bank outputs.
module mc_outer_bank #(
    parameter int REG_W     = 8,
    parameter int PRG_SLOTS = 4,
    parameter int CHR_SLOTS = 8,
    parameter int PRG_CUT   = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [REG_W-1:0]                 cfg_wdata,
    input  logic [PRG_SLOTS*REG_W-1:0]       inner_prg,
    input  logic [CHR_SLOTS*REG_W-1:0]       inner_chr,
    output logic [PRG_SLOTS*REG_W-1:0]       final_prg,
    output logic [CHR_SLOTS*(REG_W+1)-1:0]   final_chr
);
    import obm_pkg::*;

    logic [NUM_CFG-1:0][REG_W-1:0] cfg_q;
    logic [IDX_W-1:0]              idx_q;
    logic                          locked;
    logic [REG_W-1:0]              chr_mask;

    obm_cfg_regs #(.REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q),
        .idx_q   (idx_q),
        .locked  (locked)
    );

    obm_prg_map #(.REG_W(REG_W), .SLOTS(PRG_SLOTS), .CUT_W(PRG_CUT)) u_prg (
        .clr_bits   (cfg_q[PRG_CTRL]),
        .base       (cfg_q[PRG_BASE]),
        .inner      (inner_prg),
        .final_bank (final_prg)
    );

    obm_chr_map #(.REG_W(REG_W), .SLOTS(CHR_SLOTS)) u_chr (
        .size_code  (cfg_q[CHR_SIZE][3:0]),
        .hi_sel     (cfg_q[CHR_SIZE][HI_BIT]),
        .base       (cfg_q[CHR_BASE]),
        .inner      (inner_chr),
        .mask       (chr_mask),
        .final_bank (final_chr)
    );
endmodule

// File: rtl/mc_outer_bank_chk.sv
// Checker: temporal properties on the outer register file, bound into the top.
module mc_outer_bank_chk #(
    parameter int REG_W = 8
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   cfg_we,
    input logic [obm_pkg::NUM_CFG-1:0][REG_W-1:0] cfg_q,
    input logic [obm_pkg::IDX_W-1:0]              idx_q,
    input logic                                   locked,
    input logic [REG_W-1:0]                       chr_mask
);
    // R2: an accepted write steps the index by one, wrapping.
    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !locked) |=> idx_q == $past(idx_q) + 1'b1);

    // R3: no strobe, no change of index or registers.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(idx_q) && $stable(cfg_q)));

    // R4: a locked block ignores writes.
    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(idx_q) && $stable(cfg_q)));

    // R4: the lock stays set until reset.
    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R6: the decoded mask is always a contiguous run of low ones.
    p_mask_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({1'b0, chr_mask} + 1'b1));
endmodule

bind mc_outer_bank mc_outer_bank_chk #(.REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_q    (cfg_q),
    .idx_q    (idx_q),
    .locked   (locked),
    .chr_mask (chr_mask)
);

// File: tb/mc_outer_bank_test.sv
// Bench: random and directed stimulus against a reference model of the requirements.
module mc_outer_bank_test;
    localparam int W  = 8;
    localparam int NP = 4;
    localparam int NC = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [W-1:0]      cfg_wdata = '0;
    logic [NP*W-1:0]   inner_prg = '0;
    logic [NC*W-1:0]   inner_chr = '0;
    logic [NP*W-1:0]   final_prg;
    logic [NC*(W+1)-1:0] final_chr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [W-1:0] m_reg [4];
    int           m_idx;

    always #10 clk = ~clk;

    mc_outer_bank uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .inner_prg(inner_prg), .inner_chr(inner_chr),
        .final_prg(final_prg), .final_chr(final_chr)
    );

    function automatic logic [W-1:0] exp_mask(input logic [3:0] code);
        logic [W-1:0] m = '0;
        if (code[3]) for (int b = 0; b <= int'(code[2:0]); b++) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [W-1:0] exp_prg(input logic [W-1:0] inb);
        return ({2'b00, inb[5:0]} & ~{2'b00, m_reg[3][5:0]}) | m_reg[1];
    endfunction

    function automatic logic [W:0] exp_chr(input logic [W-1:0] inb);
        return {m_reg[2][4], (inb & exp_mask(m_reg[2][3:0])) | m_reg[0]};
    endfunction

    task automatic check_all(input string req);
        logic [NP*W-1:0]     ep;
        logic [NC*(W+1)-1:0] ec;
        for (int s = 0; s < NP; s++) ep[s*W +: W] = exp_prg(inner_prg[s*W +: W]);
        for (int s = 0; s < NC; s++) ec[s*(W+1) +: W+1] = exp_chr(inner_chr[s*W +: W]);
        checks++;
        if (final_prg !== ep) begin
            failures++;
            $display("FAIL %s prg actual=%h expected=%h", req, final_prg, ep);
        end else if (final_chr !== ec) begin
            failures++;
            $display("FAIL %s chr actual=%h expected=%h", req, final_chr, ec);
        end
    endtask

    // Model update for one accepted strobe, following R2 and R4.
    task automatic model_write(input logic [W-1:0] d);
        if (!m_reg[3][6]) begin
            m_reg[m_idx] = d;
            m_idx = (m_idx + 1) % 4;
        end
    endtask

    task automatic wr(input logic [W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(d);
    endtask

    task automatic rand_inner();
        inner_prg = {$urandom, $urandom};
        inner_chr = {$urandom, $urandom};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0045));
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rand_inner();
        #1 check_all("R1 reset state");

        // R2: ordered fill with distinct values, then wrap back to register 0.
        wr(8'h05); wr(8'h80); wr(8'h1B); wr(8'h0C);
        rand_inner(); #1 check_all("R2 ordered fill");
        wr(8'h21); #1 check_all("R2 wrap to reg0");
        wr(8'h40); wr(8'h19); wr(8'h03);
        #1 check_all("R2 second round");

        // R6: every size code, directed through register 2.
        for (int c = 0; c < 16; c++) begin
            wr(8'h00); wr(8'h00); wr(8'(c)); wr(8'h00);
            inner_chr = {NC{8'hFF}};
            #1 check_all("R6 mask code sweep");
            rand_inner(); #1 check_all("R7 chr combine");
        end

        // R3: idle cycles with noise on the data bus.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); cfg_wdata = 8'($urandom);
            #1 check_all("R3 idle hold");
        end

        // R5/R7: random unlocked register images and inner banks.
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] d = 8'($urandom);
            if (m_idx == 3) d[6] = 1'b0;
            wr(d);
            rand_inner();
            #1 check_all((i % 2) ? "R5 prg random" : "R7 chr random");
        end

        // R8: strobe and inner change in the same cycle.
        while (m_idx != 0) wr(8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'hA5;
        rand_inner();
        #1 check_all("R8 new inner old regs");
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(8'hA5);
        #1 check_all("R8 new regs after edge");

        // R4: lock write lands, later writes are dropped.
        wr(8'h11); wr(8'h9C); wr(8'h45);
        #1 check_all("R4 lock write accepted");
        for (int i = 0; i < 8; i++) begin
            wr(8'($urandom));
            #1 check_all("R4 locked write ignored");
        end
        rand_inner(); #1 check_all("R4 locked random inner");

        // R1: reset again clears everything, including the lock.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_idx = 0;
        #1 check_all("R1 reset clears lock");
        wr(8'h3F); #1 check_all("R1 writable after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule